// File: doc/BRIEF.md
# Receive Packet DMA Engine

This block receives packets from a streaming input and places each one into a buffer that belongs to a descriptor. It takes the descriptor from a free descriptor queue of the queue manager. A flow id travels with the stream. It indexes a small flow table, and each table entry names two queues: the free queue to pop and the destination queue that gets the filled descriptor. For every packet the engine pops one descriptor and writes the data beats into that descriptor's buffer. It then writes a header word that holds the stored length and a truncation flag, and pushes the descriptor to the destination queue.

The engine never returns descriptors to a free queue. Whoever receives a pushed descriptor must recycle it. A loopback select routes the transmit side's output stream into the receive path in place of the external receive stream. This makes the pair of engines usable for moving data from one core to another.

Memory uses word addresses. A descriptor at address D keeps its header word at D, and its buffer holds `BUF_WORDS` words from D+1 upward.

Top module: `rxdma_engine`

## Requirements
- R1: Flow table writes (`cfg_we`) store a free queue and a destination queue for entry `cfg_flow`. When a packet starts, `pop_qnum` shows the free queue stored for the flow id on that packet's first beat.
- R2: While `pop_req` is high and `pop_valid` is low (free queue empty), the stream stays stalled: both ready outputs are 0, there are no memory writes, and `pop_req` and `pop_qnum` hold.
- R3: Beat k of a packet (k counted from 0, k < `BUF_WORDS`) is written to address `pop_desc`+1+k in the same cycle that the beat is accepted, with `mem_wdata` equal to the beat data.
- R4: In the cycle after the last beat is accepted, the header is written to address D. Bit 31 of the header is the error flag, bits [LEN_W-1:0] hold the stored word count, and all other bits are zero.
- R5: In the cycle after the header write, `push_req` rises with `push_qnum` set to the flow's destination queue and `push_desc` set to D. All three hold until `push_ready` is seen high.
- R6: Beats beyond `BUF_WORDS` are accepted but not written. Such a packet's header has the error flag set and a length of `BUF_WORDS`.
- R7: When `loop_en` is 1, the engine takes its input from the `tx_*` stream and `rx_ready` is 0. When `loop_en` is 0, it takes the `rx_*` stream and `tx_ready` is 0. The stream that is not selected has no effect.
- R8: During and directly after reset, `rx_ready`, `tx_ready`, `pop_req`, `push_req` and `mem_we` are all 0. A reset in the middle of a packet abandons that packet.
- R9: Each packet causes exactly one pop and one push. `pop_req` is low from the cycle after the pop handshake, and `push_req` is low after the push handshake. There is no other queue traffic, so descriptors are never recycled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Flow table write strobe |
| cfg_flow | input | FLOW_W | Flow table entry to write |
| cfg_free_q | input | QNUM_W | Free queue number for the entry |
| cfg_dest_q | input | QNUM_W | Destination queue number for the entry |
| loop_en | input | 1 | 1 selects the transmit stream as the input |
| rx_valid | input | 1 | External receive stream valid |
| rx_ready | output | 1 | External receive stream ready |
| rx_data | input | DATA_W | External receive beat data |
| rx_last | input | 1 | Last beat of the packet |
| rx_flow | input | FLOW_W | Flow id, sampled on the first beat |
| tx_valid | input | 1 | Looped transmit stream valid |
| tx_ready | output | 1 | Looped transmit stream ready |
| tx_data | input | DATA_W | Looped transmit beat data |
| tx_last | input | 1 | Looped last beat |
| tx_flow | input | FLOW_W | Looped flow id |
| pop_req | output | 1 | Pop request to the queue manager |
| pop_qnum | output | QNUM_W | Queue to pop |
| pop_valid | input | 1 | A descriptor is available; the pop completes when this and pop_req are both high |
| pop_desc | input | ADDR_W | Popped descriptor address |
| push_req | output | 1 | Push request to the queue manager |
| push_qnum | output | QNUM_W | Queue to push to |
| push_desc | output | ADDR_W | Descriptor being pushed |
| push_ready | input | 1 | Push accepted |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The pop request appears one cycle after the first beat is offered. Each data write is due in the same cycle its beat is accepted. The header write comes one cycle after the last beat, and the push request one cycle after that. The bench drives inputs on the falling edge and samples 1 ns later. It steps through the packet phase by phase, one falling edge per cycle, and compares the values expected for that exact cycle. Queue-manager stalls of chosen length are inserted on both the pop side and the push side, so each hold is checked cycle by cycle before the handshake completes.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP,
    ST_DATA,
    ST_HDR,
    ST_PUSH
  } rx_state_e;
endpackage

// File: rtl/rxdma_flow_table.sv
module rxdma_flow_table #(
  parameter int NUM_FLOWS = 8,
  parameter int QNUM_W    = 10,
  localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [FLOW_W-1:0] cfg_flow,
  input  logic [QNUM_W-1:0] cfg_free_q,
  input  logic [QNUM_W-1:0] cfg_dest_q,
  input  logic [FLOW_W-1:0] rd_flow,
  output logic [QNUM_W-1:0] rd_free_q,
  output logic [QNUM_W-1:0] rd_dest_q
);
  logic [QNUM_W-1:0] free_tab [NUM_FLOWS];
  logic [QNUM_W-1:0] dest_tab [NUM_FLOWS];

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_entry
    wire entry_wr = cfg_we && (cfg_flow == FLOW_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        free_tab[g] <= '0;
        dest_tab[g] <= '0;
      end else if (entry_wr) begin
        free_tab[g] <= cfg_free_q;
        dest_tab[g] <= cfg_dest_q;
      end
    end
  end

  assign rd_free_q = free_tab[rd_flow];
  assign rd_dest_q = dest_tab[rd_flow];

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_flow == rd_flow) |=>
      (rd_flow != $past(rd_flow)) || (rd_free_q == $past(cfg_free_q) && rd_dest_q == $past(cfg_dest_q))); // R1
endmodule

// File: rtl/rxdma_src_mux.sv
module rxdma_src_mux #(
  parameter int DATA_W = 32,
  parameter int FLOW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic [FLOW_W-1:0] rx_flow,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic [FLOW_W-1:0] tx_flow,
  input  logic              eng_ready,
  output logic              in_valid,
  output logic [DATA_W-1:0] in_data,
  output logic              in_last,
  output logic [FLOW_W-1:0] in_flow
);
  always_comb begin
    if (loop_en) begin
      in_valid = tx_valid;
      in_data  = tx_data;
      in_last  = tx_last;
      in_flow  = tx_flow;
    end else begin
      in_valid = rx_valid;
      in_data  = rx_data;
      in_last  = rx_last;
      in_flow  = rx_flow;
    end
  end

  assign rx_ready = eng_ready && !loop_en;
  assign tx_ready = eng_ready && loop_en;

  AST_LOOP_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_ready)); // R7
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int QNUM_W    = 10,
  parameter int FLOW_W    = 3,
  parameter int BUF_WORDS = 4,
  localparam int LEN_W    = $clog2(BUF_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [FLOW_W-1:0] in_flow,
  output logic              in_ready,
  output logic [FLOW_W-1:0] cur_flow,
  input  logic [QNUM_W-1:0] free_q,
  input  logic [QNUM_W-1:0] dest_q,
  output logic              pop_req,
  output logic [QNUM_W-1:0] pop_qnum,
  input  logic              pop_valid,
  input  logic [ADDR_W-1:0] pop_desc,
  output logic              push_req,
  output logic [QNUM_W-1:0] push_qnum,
  output logic [ADDR_W-1:0] push_desc,
  input  logic              push_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_WORDS);

  function automatic logic [ADDR_W-1:0] buf_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [LEN_W-1:0]  idx);
    return base + ADDR_W'(idx) + ADDR_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] hdr_word(input logic err, input logic [LEN_W-1:0] len);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1] = err;
    w[LEN_W-1:0] = len;
    return w;
  endfunction

  rx_state_e         st_q;
  logic [FLOW_W-1:0] flow_q;
  logic [ADDR_W-1:0] desc_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              err_q;

  // named internal events
  wire room     = cnt_q < CAP;
  wire beat_acc = in_valid && in_ready;
  wire data_we  = beat_acc && room;
  wire hdr_we   = (st_q == ST_HDR);
  wire pop_fire = pop_req && pop_valid;
  wire push_fire = push_req && push_ready;

  assign in_ready  = (st_q == ST_DATA);
  assign cur_flow  = flow_q;
  assign pop_req   = (st_q == ST_POP);
  assign pop_qnum  = free_q;
  assign push_req  = (st_q == ST_PUSH);
  assign push_qnum = dest_q;
  assign push_desc = desc_q;
  assign mem_we    = data_we || hdr_we;
  assign mem_addr  = hdr_we ? desc_q : buf_addr(desc_q, cnt_q);
  assign mem_wdata = hdr_we ? hdr_word(err_q, cnt_q) : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flow_q <= '0;
      desc_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_valid) begin
          flow_q <= in_flow;
          st_q   <= ST_POP;
        end
        ST_POP: if (pop_fire) begin
          desc_q <= pop_desc;
          cnt_q  <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_DATA;
        end
        ST_DATA: if (beat_acc) begin
          if (room) cnt_q <= cnt_q + LEN_W'(1);
          else      err_q <= 1'b1;
          if (in_last) st_q <= ST_HDR;
        end
        ST_HDR: st_q <= ST_PUSH;
        ST_PUSH: if (push_fire) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_POP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !pop_valid |=> pop_req && $stable(pop_qnum)); // R2
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> !mem_we && !in_ready); // R2
  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> !data_we || mem_addr == $past(mem_addr) + ADDR_W'(1)); // R3
  AST_HDR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_acc && in_last |=> hdr_we && mem_we && mem_addr == desc_q); // R4
  AST_PUSH_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |=> push_req && push_desc == $past(mem_addr)); // R5
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ready |=> push_req && $stable(push_desc) && $stable(push_qnum)); // R5
  AST_TRUNC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we && mem_wdata[DATA_W-1] |-> mem_wdata[LEN_W-1:0] == CAP); // R6
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> !pop_req && !push_req); // R9
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> !push_req && !pop_req); // R9
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
  parameter int NUM_FLOWS = 8,
  parameter int QNUM_W    = 10,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 4,
  localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [FLOW_W-1:0] cfg_flow,
  input  logic [QNUM_W-1:0] cfg_free_q,
  input  logic [QNUM_W-1:0] cfg_dest_q,
  input  logic              loop_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic [FLOW_W-1:0] rx_flow,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic [FLOW_W-1:0] tx_flow,
  output logic              pop_req,
  output logic [QNUM_W-1:0] pop_qnum,
  input  logic              pop_valid,
  input  logic [ADDR_W-1:0] pop_desc,
  output logic              push_req,
  output logic [QNUM_W-1:0] push_qnum,
  output logic [ADDR_W-1:0] push_desc,
  input  logic              push_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              in_valid, in_last, eng_ready;
  logic [DATA_W-1:0] in_data;
  logic [FLOW_W-1:0] in_flow, cur_flow;
  logic [QNUM_W-1:0] free_q, dest_q;

  rxdma_src_mux #(.DATA_W(DATA_W), .FLOW_W(FLOW_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_flow(rx_flow),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_flow(tx_flow),
    .eng_ready(eng_ready),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_flow(in_flow)
  );

  rxdma_flow_table #(.NUM_FLOWS(NUM_FLOWS), .QNUM_W(QNUM_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
    .cfg_free_q(cfg_free_q), .cfg_dest_q(cfg_dest_q),
    .rd_flow(cur_flow), .rd_free_q(free_q), .rd_dest_q(dest_q)
  );

  rxdma_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .QNUM_W(QNUM_W), .FLOW_W(FLOW_W),
               .BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_flow(in_flow),
    .in_ready(eng_ready), .cur_flow(cur_flow), .free_q(free_q), .dest_q(dest_q),
    .pop_req(pop_req), .pop_qnum(pop_qnum), .pop_valid(pop_valid), .pop_desc(pop_desc),
    .push_req(push_req), .push_qnum(push_qnum), .push_desc(push_desc), .push_ready(push_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !pop_req && !push_req && !mem_we && !rx_ready && !tx_ready); // R8
endmodule

// File: tb/rxdma_engine_tb_top.sv
`timescale 1ns/1ps
module rxdma_engine_tb_top;
  localparam int NF = 8, QW = 10, AW = 16, DW = 32, BW = 4, FW = 3, LW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [FW-1:0] cfg_flow = '0; logic [QW-1:0] cfg_free_q = '0, cfg_dest_q = '0;
  logic loop_en = 0;
  logic rx_valid = 0, rx_last = 0, tx_valid = 0, tx_last = 0, rx_ready, tx_ready;
  logic [DW-1:0] rx_data = '0, tx_data = '0;
  logic [FW-1:0] rx_flow = '0, tx_flow = '0;
  logic pop_req, pop_valid = 0, push_req, push_ready = 0, mem_we;
  logic [QW-1:0] pop_qnum, push_qnum;
  logic [AW-1:0] pop_desc = '0, push_desc, mem_addr;
  logic [DW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  rxdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_free_q(cfg_free_q),
    .cfg_dest_q(cfg_dest_q), .loop_en(loop_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_flow(rx_flow),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_flow(tx_flow),
    .pop_req(pop_req), .pop_qnum(pop_qnum), .pop_valid(pop_valid), .pop_desc(pop_desc),
    .push_req(push_req), .push_qnum(push_qnum), .push_desc(push_desc), .push_ready(push_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  typedef struct packed {
    logic [2:0]  flow;
    logic [3:0]  nb;
    logic        loop;
    logic [15:0] desc;
    logic [3:0]  popd;
    logic [3:0]  pushd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 4'd1, 1'b0, 16'h0100, 4'd0, 4'd0},
    '{3'd3, 4'd4, 1'b0, 16'h0200, 4'd2, 4'd1},
    '{3'd7, 4'd6, 1'b0, 16'h0300, 4'd0, 4'd2},
    '{3'd5, 4'd3, 1'b1, 16'h0400, 4'd1, 4'd0},
    '{3'd1, 4'd5, 1'b1, 16'h0500, 4'd0, 4'd1},
    '{3'd6, 4'd2, 1'b0, 16'h0600, 4'd3, 4'd0}
  };

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [QW-1:0] exp_free [NF];
  logic [QW-1:0] exp_dest [NF];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat_val(input logic [AW-1:0] d, input int i);
    return {8'hB0, d, 8'(i)};
  endfunction

  task automatic cfg(input int f, input logic [QW-1:0] fr, input logic [QW-1:0] de);
    @(negedge clk);
    cfg_we = 1; cfg_flow = FW'(f); cfg_free_q = fr; cfg_dest_q = de;
    @(negedge clk);
    cfg_we = 0;
    exp_free[f] = fr; exp_dest[f] = de;
  endtask

  task automatic drive(input vec_t v, input int i, input bit on);
    // selected stream carries the packet; the other one offers junk for R7
    if (v.loop) begin
      tx_valid = on; tx_data = beat_val(v.desc, i); tx_last = (i == int'(v.nb) - 1); tx_flow = v.flow;
      rx_valid = on; rx_data = 32'hDEAD_0000; rx_last = 1; rx_flow = 3'd7;
    end else begin
      rx_valid = on; rx_data = beat_val(v.desc, i); rx_last = (i == int'(v.nb) - 1); rx_flow = v.flow;
      tx_valid = on; tx_data = 32'hDEAD_0000; tx_last = 1; tx_flow = 3'd7;
    end
  endtask

  task automatic run_pkt(input vec_t v);
    int nb;
    logic sel_rdy, oth_rdy;
    logic [DW-1:0] hdr;
    nb = int'(v.nb);
    @(negedge clk);
    loop_en = v.loop;
    drive(v, 0, 1);
    do begin @(negedge clk); #1; end while (!pop_req);
    chk("R1", "pop_qnum", 64'(pop_qnum), 64'(exp_free[v.flow]));
    for (int s = 0; s < int'(v.popd); s++) begin
      chk("R2", "ready during stall", 64'({rx_ready, tx_ready, mem_we}), 64'(0));
      @(negedge clk); #1;
      chk("R2", "pop held", 64'({pop_req, pop_qnum}), 64'({1'b1, exp_free[v.flow]}));
    end
    pop_valid = 1; pop_desc = v.desc;
    @(negedge clk);
    pop_valid = 0; pop_desc = 16'hFFFF;
    #1;
    chk("R9", "pop released", 64'(pop_req), 64'(0));
    for (int i = 0; i < nb; i++) begin
      sel_rdy = v.loop ? tx_ready : rx_ready;
      oth_rdy = v.loop ? rx_ready : tx_ready;
      chk("R7", "ready routing", 64'({sel_rdy, oth_rdy}), 64'({1'b1, 1'b0}));
      if (i < BW)
        chk("R3", "beat write", 64'({mem_we, mem_addr, mem_wdata}),
            64'({1'b1, v.desc + AW'(1 + i), beat_val(v.desc, i)}));
      else
        chk("R6", "no write past buffer", 64'(mem_we), 64'(0));
      @(negedge clk);
      if (i + 1 < nb) drive(v, i + 1, 1); else drive(v, 0, 0);
      #1;
    end
    hdr = '0;
    hdr[DW-1] = (nb > BW);
    hdr[LW-1:0] = LW'((nb > BW) ? BW : nb);
    chk(nb > BW ? "R6" : "R4", "header", 64'({mem_we, mem_addr, mem_wdata}), 64'({1'b1, v.desc, hdr}));
    @(negedge clk); #1;
    chk("R5", "push", 64'({push_req, push_qnum, push_desc}), 64'({1'b1, exp_dest[v.flow], v.desc}));
    for (int s = 0; s < int'(v.pushd); s++) begin
      @(negedge clk); #1;
      chk("R5", "push held", 64'({push_req, push_qnum, push_desc}), 64'({1'b1, exp_dest[v.flow], v.desc}));
    end
    push_ready = 1;
    @(negedge clk);
    push_ready = 0;
    #1;
    chk("R9", "queues idle after push", 64'({push_req, pop_req, mem_we}), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t dv;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "outputs in reset", 64'({rx_ready, tx_ready, pop_req, push_req, mem_we}), 64'(0));
    rst_n = 1;
    @(negedge clk); #1;
    chk("R8", "outputs after reset", 64'({rx_ready, tx_ready, pop_req, push_req, mem_we}), 64'(0));
    for (int f = 0; f < NF; f++) cfg(f, QW'(16 + 3 * f), QW'(512 + 5 * f));

    // table-driven packets
    for (int k = 0; k < 6; k++) run_pkt(VECS[k]);

    // R1: rewriting an entry changes the queues used by the next packet on that flow
    cfg(2, 10'd77, 10'd901);
    dv = '{3'd2, 4'd2, 1'b1, 16'h0700, 4'd0, 4'd0};
    run_pkt(dv);

    // R8: reset in the middle of a packet abandons it
    dv = '{3'd4, 4'd3, 1'b0, 16'h0800, 4'd0, 4'd0};
    @(negedge clk);
    loop_en = 0;
    drive(dv, 0, 1);
    do begin @(negedge clk); #1; end while (!pop_req);
    pop_valid = 1; pop_desc = dv.desc;
    @(negedge clk);
    pop_valid = 0;
    rst_n = 0;
    @(negedge clk); #1;
    chk("R8", "mid-packet reset", 64'({rx_ready, tx_ready, pop_req, push_req, mem_we}), 64'(0));
    drive(dv, 0, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R8", "idle after reset", 64'({rx_ready, pop_req, push_req, mem_we}), 64'(0));

    // flow table was cleared by reset: reload entry 0 and check a single-beat packet still works
    cfg(0, 10'd33, 10'd44);
    dv = '{3'd0, 4'd1, 1'b0, 16'h0900, 4'd1, 4'd0};
    run_pkt(dv);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule